// File: doc/BRIEF.md
# Self-Synchronizing PRBS Error Checker

This block is the receive-side checker of a bit-error-rate tester. Every clock it takes one 40-bit word from a deserializer and a pattern select that must agree with the far-end generator (PRBS7, PRBS23 or PRBS31). It predicts the word it should have received, compares the two bit by bit, and reports how many bits of that word were wrong. While hunting for lock, it derives its prediction from the previous received word. Once lock is declared, it runs its predictor from its own stored state, so line errors cannot corrupt the reference sequence.

Lock is declared after seven clean words in a row and dropped after seven errored words in a row. Dropping lock puts the checker back into hunting mode. While locked, a saturating total of bit errors is kept. Each errored word produces a log record carrying the error count and a cycle timestamp, written to an external FIFO when it has room. If the FIFO is full, a sticky overflow flag is raised instead.

Top module: `prbs_err_checker`

## Requirements
- R1: `pat_sel` selects the recurrence b[n] = b[n-N] ^ b[n-T] of the serial stream: 0 gives N=7,T=6; 1 gives N=23,T=18; 2 gives N=31,T=28; 3 behaves as 2. Bit 0 of a word is the earliest bit of that word.
- R2: While unlocked, the expected word is the continuation of the previous received word under the selected recurrence, so an error in one received word also shows up as errors in the next word.
- R3: While unlocked, lock is declared when seven consecutive words match their expected words. Any mismatching word restarts the count. `link_up` rises after the clock edge that captures the seventh matching word.
- R4: While locked, the expected word is the continuation of the checker's previous expected word. Received errors do not change later expectations.
- R5: While locked, `link_up` falls after the edge that captures the seventh consecutive errored word. Any clean word restarts that count.
- R6: After lock is lost, the checker hunts again from received data and can lock onto a stream with a new phase.
- R7: `word_err_cnt` is the number of differing bits (0 to 40) between the word captured at an edge and its expected word. It is valid right after that edge, in both modes.
- R8: `bit_err_total` adds `word_err_cnt` only for words captured while `link_up` was 1 before the edge. It saturates at all ones and does not wrap.
- R9: The timestamp is a free-running cycle counter cleared by reset. The word captured at the k-th edge after reset release (counting from 0) carries stamp k.
- R10: A locked, errored word with `fifo_full` low gives a one-cycle `log_wr` pulse, with `log_cnt` set to its error count and `log_time` set to its stamp.
- R11: A locked, errored word with `fifo_full` high gives no `log_wr` and sets `log_overflow`, which stays high until reset.
- R12: Synchronous active-low reset clears `link_up`, `word_err_cnt`, `bit_err_total`, `log_wr` and `log_overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pat_sel | input | 2 | Pattern select (R1) |
| rx_word | input | 40 | Received word from the deserializer |
| fifo_full | input | 1 | Log FIFO cannot accept a record |
| link_up | output | 1 | Lock status |
| word_err_cnt | output | 6 | Bit errors in the last captured word |
| bit_err_total | output | TOT_W | Saturating locked-error total |
| log_wr | output | 1 | Log record write strobe |
| log_cnt | output | 6 | Error count of the logged word |
| log_time | output | TS_W | Timestamp of the logged word |
| log_overflow | output | 1 | Sticky record-lost flag |

## Verification
The bench corrupts one word while hunting and one word while locked. A checker that used its own state before lock would miss the error spreading into the next word. A checker that reseeded while locked would report a second errored word. Runs of six errored or clean words followed by a word of the opposite kind target off-by-one lock and unlock counters, since a wrong counter would change `link_up` one word early or fail to restart. A phase jump after lock loss catches a checker that stays on its stale internal state. Repeated 40-bit error words drive the small total counter past its limit, which exposes wrap-around. Logging with a full FIFO exposes a flag that clears itself or a write that still goes out.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

  localparam int WORD_W = 40;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {
    PAT_P7   = 2'd0,
    PAT_P23  = 2'd1,
    PAT_P31  = 2'd2,
    PAT_P31X = 2'd3
  } pat_sel_e;

  function automatic int pat_len(input pat_sel_e s);
    case (s)
      PAT_P7:  return 7;
      PAT_P23: return 23;
      default: return 31;
    endcase
  endfunction

  function automatic int pat_tap(input pat_sel_e s);
    case (s)
      PAT_P7:  return 6;
      PAT_P23: return 18;
      default: return 28;
    endcase
  endfunction

  // Continue the serial recurrence for one whole word past cur.
  function automatic logic [WORD_W-1:0] prbs_advance(input logic [WORD_W-1:0] cur,
                                                     input pat_sel_e s);
    logic [2*WORD_W-1:0] ext;
    int n;
    int t;
    n   = pat_len(s);
    t   = pat_tap(s);
    ext = {{WORD_W{1'b0}}, cur};
    for (int i = WORD_W; i < 2*WORD_W; i++) begin
      ext[i] = ext[i-n] ^ ext[i-t];
    end
    return ext[2*WORD_W-1:WORD_W];
  endfunction

  function automatic logic [CNT_W-1:0] bit_count(input logic [WORD_W-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < WORD_W; i++) begin
      c = c + {{(CNT_W-1){1'b0}}, v[i]};
    end
    return c;
  endfunction

endpackage

// File: rtl/prbs_predictor.sv
module prbs_predictor
  import prbs_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  pat_sel_e          sel,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              locked,
  output logic [WORD_W-1:0] exp_word
);

  logic [WORD_W-1:0] prev_rx;
  logic [WORD_W-1:0] own_state;
  logic [WORD_W-1:0] seed;

  always_comb begin
    seed     = locked ? own_state : prev_rx;
    exp_word = prbs_advance(seed, sel);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_rx   <= '0;
      own_state <= '0;
    end else begin
      prev_rx   <= rx_word;
      own_state <= exp_word;
    end
  end

endmodule

// File: rtl/lock_tracker.sv
module lock_tracker #(
  parameter int RUN_LEN = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic word_bad,
  output logic link_up
);

  localparam int RUN_W = $clog2(RUN_LEN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0] run;
  logic             run_hit;

  // A word that argues against the current state extends the run.
  assign run_hit = link_up ? word_bad : !word_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= '0;
      link_up <= 1'b0;
    end else if (!run_hit) begin
      run <= '0;
    end else if (run == RUN_LAST) begin
      run     <= '0;
      link_up <= !link_up;
    end else begin
      run <= run + 1'b1;
    end
  end

endmodule

// File: rtl/err_tally.sv
module err_tally
  import prbs_chk_pkg::*;
#(
  parameter int TOT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] word_bits,
  input  logic             locked,
  output logic [CNT_W-1:0] word_err_cnt,
  output logic [TOT_W-1:0] total
);

  localparam int SUM_W = TOT_W + 1;

  logic [SUM_W-1:0] sum;

  assign sum = {1'b0, total} + SUM_W'(word_bits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_err_cnt <= '0;
      total        <= '0;
    end else begin
      word_err_cnt <= word_bits;
      if (locked) begin
        total <= sum[TOT_W] ? '1 : sum[TOT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/err_logger.sv
module err_logger
  import prbs_chk_pkg::*;
#(
  parameter int TS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] word_bits,
  input  logic             locked,
  input  logic             fifo_full,
  output logic             log_wr,
  output logic [CNT_W-1:0] log_cnt,
  output logic [TS_W-1:0]  log_time,
  output logic             overflow
);

  logic [TS_W-1:0] stamp;
  logic            hit;

  assign hit = locked && (word_bits != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stamp    <= '0;
      log_wr   <= 1'b0;
      log_cnt  <= '0;
      log_time <= '0;
      overflow <= 1'b0;
    end else begin
      stamp  <= stamp + 1'b1;
      log_wr <= hit && !fifo_full;
      if (hit && !fifo_full) begin
        log_cnt  <= word_bits;
        log_time <= stamp;
      end
      if (hit && fifo_full) begin
        overflow <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/prbs_err_checker.sv
module prbs_err_checker
  import prbs_chk_pkg::*;
#(
  parameter int TOT_W    = 32,
  parameter int TS_W     = 32,
  parameter int LOCK_RUN = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pat_sel,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              fifo_full,
  output logic              link_up,
  output logic [CNT_W-1:0]  word_err_cnt,
  output logic [TOT_W-1:0]  bit_err_total,
  output logic              log_wr,
  output logic [CNT_W-1:0]  log_cnt,
  output logic [TS_W-1:0]   log_time,
  output logic              log_overflow
);

  logic [WORD_W-1:0] exp_word;
  logic [CNT_W-1:0]  word_bits;
  logic              word_bad;

  assign word_bits = bit_count(rx_word ^ exp_word);
  assign word_bad  = (word_bits != '0);

  prbs_predictor u_pred (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (pat_sel_e'(pat_sel)),
    .rx_word  (rx_word),
    .locked   (link_up),
    .exp_word (exp_word)
  );

  lock_tracker #(.RUN_LEN(LOCK_RUN)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_bad (word_bad),
    .link_up  (link_up)
  );

  err_tally #(.TOT_W(TOT_W)) u_tally (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_bits    (word_bits),
    .locked       (link_up),
    .word_err_cnt (word_err_cnt),
    .total        (bit_err_total)
  );

  err_logger #(.TS_W(TS_W)) u_log (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_bits (word_bits),
    .locked    (link_up),
    .fifo_full (fifo_full),
    .log_wr    (log_wr),
    .log_cnt   (log_cnt),
    .log_time  (log_time),
    .overflow  (log_overflow)
  );

endmodule

// File: rtl/prbs_err_checker_sva.sv
module prbs_err_checker_sva #(
  parameter int TOT_W = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_full,
  input logic             link_up,
  input logic [CNT_W-1:0] word_err_cnt,
  input logic [TOT_W-1:0] bit_err_total,
  input logic             log_wr,
  input logic [CNT_W-1:0] log_cnt,
  input logic             log_overflow
);

  assert_rise_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> word_err_cnt == '0);

  assert_fall_errored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_up) |-> word_err_cnt != '0);

  assert_total_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(link_up)) |-> $stable(bit_err_total));

  assert_total_monotone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> bit_err_total >= $past(bit_err_total));

  assert_log_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    log_wr |-> log_cnt != '0);

  assert_log_room_R11: assert property (@(posedge clk) disable iff (!rst_n)
    log_wr |-> !$past(fifo_full));

  assert_ovf_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(log_overflow) |-> $past(fifo_full));

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(log_overflow)) |-> log_overflow);

endmodule

bind prbs_err_checker prbs_err_checker_sva #(.TOT_W(TOT_W), .CNT_W(CNT_W)) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .fifo_full     (fifo_full),
  .link_up       (link_up),
  .word_err_cnt  (word_err_cnt),
  .bit_err_total (bit_err_total),
  .log_wr        (log_wr),
  .log_cnt       (log_cnt),
  .log_overflow  (log_overflow)
);

// File: tb/prbs_err_checker_tb_top.sv
`timescale 1ns/1ps
module prbs_err_checker_tb_top;

  localparam int TOT_W = 8;
  localparam int TS_W  = 16;
  localparam logic [39:0] ALL_BITS = {40{1'b1}};
  localparam logic [39:0] TOP_BIT  = 40'h80_0000_0000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       pat_sel = 2'd0;
  logic [39:0]      rx_word = '0;
  logic             fifo_full = 1'b0;
  logic             link_up;
  logic [5:0]       word_err_cnt;
  logic [TOT_W-1:0] bit_err_total;
  logic             log_wr;
  logic [5:0]       log_cnt;
  logic [TS_W-1:0]  log_time;
  logic             log_overflow;

  int n_checks = 0;
  int n_errors = 0;
  int pn = 7;
  int pt = 6;
  logic [63:0] hist;
  logic        model_up = 1'b0;
  int          exp_tot = 0;
  logic [31:0] tb_cyc = '0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) tb_cyc <= '0;
    else        tb_cyc <= tb_cyc + 1;
  end

  prbs_err_checker #(.TOT_W(TOT_W), .TS_W(TS_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .rx_word(rx_word),
    .fifo_full(fifo_full), .link_up(link_up), .word_err_cnt(word_err_cnt),
    .bit_err_total(bit_err_total), .log_wr(log_wr), .log_cnt(log_cnt),
    .log_time(log_time), .log_overflow(log_overflow)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Serial bench model of the recurrence, one bit at a time.
  task automatic gen_word(output logic [39:0] w);
    for (int j = 0; j < 40; j++) begin
      logic nb;
      nb = hist[pn-1] ^ hist[pt-1];
      hist = {hist[62:0], nb};
      w[j] = nb;
    end
  endtask

  // Drive one word (stream word XOR mask), capture, and check counts and logging.
  task automatic send(input logic [39:0] mask);
    logic [39:0] w;
    int pc;
    gen_word(w);
    pc = $countones(mask);
    @(negedge clk);
    rx_word = w ^ mask;
    @(posedge clk);
    #1;
    if (model_up) begin
      chk("R7 word count locked", 64'(word_err_cnt), 64'(pc));
      exp_tot = (exp_tot + pc > 255) ? 255 : exp_tot + pc;
      chk("R8 total", 64'(bit_err_total), 64'(exp_tot));
      if (pc != 0) begin
        chk("R10/R11 log strobe", 64'(log_wr), 64'(!fifo_full));
        if (!fifo_full) begin
          chk("R10 log count", 64'(log_cnt), 64'(pc));
          chk("R9 log stamp", 64'(log_time), 64'(TS_W'(tb_cyc - 1)));
        end
      end else begin
        chk("R10 no log on clean word", 64'(log_wr), 64'd0);
      end
    end
  endtask

  task automatic start_mode(input logic [1:0] sel);
    @(negedge clk);
    rst_n = 1'b0;
    pat_sel = sel;
    fifo_full = 1'b0;
    case (sel)
      2'd0: begin pn = 7;  pt = 6;  end
      2'd1: begin pn = 23; pt = 18; end
      default: begin pn = 31; pt = 28; end
    endcase
    hist = 64'hACE1_3579_BDF0_2468;
    model_up = 1'b0;
    exp_tot = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    start_mode(2'd0);
    #1;
    chk("R12 link_up", 64'(link_up), 64'd0);
    chk("R12 word count", 64'(word_err_cnt), 64'd0);
    chk("R12 total", 64'(bit_err_total), 64'd0);
    chk("R12 log_wr", 64'(log_wr), 64'd0);
    chk("R12 overflow", 64'(log_overflow), 64'd0);
  endtask

  // First word mismatches the zero seed, then seven clean words lock.
  task automatic t_lock(input logic [1:0] sel);
    start_mode(sel);
    send('0);
    chk("R8 no count while hunting", 64'(bit_err_total), 64'd0);
    for (int k = 0; k < 6; k++) begin
      send('0);
      chk("R2 hunting match", 64'(word_err_cnt), 64'd0);
    end
    chk("R3 not yet up after six", 64'(link_up), 64'd0);
    send('0);
    chk("R1/R3 up after seven", 64'(link_up), 64'd1);
    model_up = 1'b1;
  endtask

  task automatic t_hunt_interrupt;
    start_mode(2'd0);
    send('0);
    for (int k = 0; k < 5; k++) send('0);
    send(TOP_BIT);
    chk("R3 bad word while hunting", 64'(word_err_cnt), 64'd1);
    send('0);
    chk("R2 error spreads while hunting", 64'(word_err_cnt != 0), 64'd1);
    for (int k = 0; k < 6; k++) send('0);
    chk("R3 restart needs seven fresh", 64'(link_up), 64'd0);
    send('0);
    chk("R3 up after fresh seven", 64'(link_up), 64'd1);
    model_up = 1'b1;
  endtask

  task automatic t_locked_error;
    t_lock(2'd1);
    send(TOP_BIT);
    send('0);
    chk("R4 no spread while locked", 64'(word_err_cnt), 64'd0);
    chk("R4 still up", 64'(link_up), 64'd1);
  endtask

  task automatic t_drop_relock;
    t_lock(2'd0);
    for (int k = 0; k < 6; k++) send(ALL_BITS);
    chk("R5 up after six bad", 64'(link_up), 64'd1);
    send('0);
    for (int k = 0; k < 6; k++) send(ALL_BITS);
    chk("R5 clean word restarted run", 64'(link_up), 64'd1);
    chk("R8 saturated", 64'(bit_err_total), 64'd255);
    send(ALL_BITS);
    chk("R5 down after seven bad", 64'(link_up), 64'd0);
    model_up = 1'b0;
    hist = 64'h1357_9BDF_0246_8ACE;
    send('0);
    for (int k = 0; k < 6; k++) send('0);
    chk("R6 still hunting", 64'(link_up), 64'd0);
    send('0);
    chk("R6 relocked on new phase", 64'(link_up), 64'd1);
    chk("R8 total held while down", 64'(bit_err_total), 64'd255);
  endtask

  task automatic t_overflow;
    t_lock(2'd2);
    fifo_full = 1'b1;
    model_up = 1'b1;
    send(40'h00_0000_0007);
    chk("R11 overflow set", 64'(log_overflow), 64'd1);
    fifo_full = 1'b0;
    send(40'h10_0000_0001);
    chk("R11 overflow sticky", 64'(log_overflow), 64'd1);
    send('0);
    chk("R11 overflow still set", 64'(log_overflow), 64'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin : main
    t_reset();
    t_lock(2'd0);
    t_lock(2'd1);
    t_lock(2'd2);
    t_lock(2'd3);
    t_hunt_interrupt();
    t_locked_error();
    t_drop_relock();
    t_overflow();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule